// File: doc/BRIEF.md
# Indexed Address Translation Window Unit

This block keeps a bank of programmable address translation windows. Half of them serve the outbound direction (processor side toward the link), half serve the inbound direction (link toward the processor). Software reaches every window through one small shared register group. A viewport select register decides which direction and which window index that group currently addresses. Field writes only stage values. The staged set becomes live when the window's enable control register is written.

The translation port takes an address and a direction flag, and returns the result one clock later. The result is a hit flag and the kind of access. A memory-type window remaps the address from its base onto its target and returns the remapped address. A configuration-type window takes the bus and device/function numbers from its target and returns them, together with the offset into configuration space. Two status registers always read back "link up" and "speed change complete", so that driver polling loops finish.

Top module: `atu_window_unit`

## Requirements
- R1: Register 0x900 selects the viewport. Bit 31 picks the direction (1 inbound, 0 outbound) and bits [IDXW-1:0] pick the window index. A write keeps only those bits, and a read returns the kept bits with every other bit zero.
- R2: The selected window's staged fields are read and written at these offsets: 0x904 type (value 0 means memory, any other value means configuration), 0x908 enable control (bit 31 enables), 0x90C/0x910 base low/high words, 0x914 the 32-bit limit, 0x918/0x91C target low/high words.
- R3: Writes to the type, base, limit and target fields do not change translation. A write to 0x908 copies the window's staged fields into the live set and sets the live enable from bit 31 of the written data. The live type is the staged type at that moment, so changing the type takes effect on this write too.
- R4: An address hits a window when the window is live-enabled, belongs to the requested direction (xl_inbound=1 selects inbound), and lies from base up to the zero-extended limit, both ends included.
- R5: On a memory-type hit, xl_out_addr = target + (address - base) modulo 2^64, and xl_is_cfg = 0.
- R6: On a configuration-type hit, xl_is_cfg = 1, xl_bus = target[31:24], xl_devfn = target[23:16], xl_cfg_off = the low CFG_OFS_W bits of (address - base), and xl_out_addr = 0.
- R7: When several windows of the requested direction hit, the lowest window index decides the result.
- R8: On a miss every translation output is zero, and outputs that do not apply to the access type are zero as well.
- R9: After reset every window has base 0, target 0, limit 0xFFFFFFFF and memory type, and the viewport register reads 0. Only inbound window 0 is enabled, so inbound addresses up to 0xFFFFFFFF translate to themselves, while every outbound address misses.
- R10: Offset 0x80C always reads 0x00020000 and offset 0x72C always reads 0x00000010, and writes to them change nothing. Any offset not listed here reads 0.
- R11: Translation outputs reflect the inputs sampled at the previous rising edge. reg_rdata holds the value read at the last edge where reg_rd was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| xl_addr | input | 64 | Address to translate |
| xl_inbound | input | 1 | Direction: 1 inbound, 0 outbound |
| xl_hit | output | 1 | A window hit |
| xl_is_cfg | output | 1 | Hit window is configuration type |
| xl_out_addr | output | 64 | Translated address (memory type) |
| xl_bus | output | 8 | Bus number (configuration type) |
| xl_devfn | output | 8 | Device/function (configuration type) |
| xl_cfg_off | output | CFG_OFS_W | Offset into configuration space |

## Verification
The assertions assume that reset is held high for at least one clock edge before use. They also assume that reg_wr and reg_rd are never high in the same cycle, because a read then returns the value from before the write. The stimulus drives each strobe on its own, one access at a time, and always away from the clock edge. Random base and limit values are kept inside a narrow low address range, with upper words that are usually zero. This makes hits, overlapping windows and boundary misses frequent, while the translation inputs may still change every cycle.

// File: rtl/atu_pkg.sv
package atu_pkg;
  // Register offsets; the window group layout is decoded by software drivers.
  localparam logic [11:0] OFS_PHY_DBG  = 12'h72C;
  localparam logic [11:0] OFS_LINK_SPD = 12'h80C;
  localparam logic [11:0] OFS_VPSEL    = 12'h900;
  localparam logic [11:0] OFS_CTL1     = 12'h904;
  localparam logic [11:0] OFS_CTL2     = 12'h908;
  localparam logic [11:0] OFS_BASE_LO  = 12'h90C;
  localparam logic [11:0] OFS_BASE_HI  = 12'h910;
  localparam logic [11:0] OFS_LIMIT    = 12'h914;
  localparam logic [11:0] OFS_TGT_LO   = 12'h918;
  localparam logic [11:0] OFS_TGT_HI   = 12'h91C;

  localparam logic [31:0] PHY_DBG_VAL  = 32'h0000_0010;
  localparam logic [31:0] LINK_SPD_VAL = 32'h0002_0000;

  // Live (committed) window state used by the translation path.
  typedef struct packed {
    logic [63:0] base;
    logic [31:0] limit;
    logic [63:0] target;
    logic        is_cfg;
    logic        en;
  } win_t;
endpackage

// File: rtl/atu_regfile.sv
module atu_regfile
  import atu_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDXW  = $clog2(NUM_WIN),
  localparam int NSLOT = 2 * NUM_WIN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [11:0]           reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output win_t [NSLOT-1:0]      act_o
);
  logic            vp_dir;
  logic [IDXW-1:0] vp_idx;
  logic [IDXW:0]   sel;
  assign sel = {vp_dir, vp_idx};

  // Staged fields, visible to software.
  logic [63:0] sh_base [NSLOT];
  logic [63:0] sh_tgt  [NSLOT];
  logic [31:0] sh_lim  [NSLOT];
  logic [31:0] sh_ctl1 [NSLOT];
  logic [31:0] sh_ctl2 [NSLOT];
  win_t        act_q   [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_out
    assign act_o[s] = act_q[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vp_dir <= 1'b0;
      vp_idx <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        sh_base[s] <= '0;
        sh_tgt[s]  <= '0;
        sh_lim[s]  <= 32'hFFFF_FFFF;
        sh_ctl1[s] <= '0;
        sh_ctl2[s] <= (s == NUM_WIN) ? 32'h8000_0000 : 32'h0;
        act_q[s]   <= '{base: 64'h0, limit: 32'hFFFF_FFFF, target: 64'h0,
                        is_cfg: 1'b0, en: (s == NUM_WIN)};
      end
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_VPSEL: begin
          vp_dir <= reg_wdata[31];
          vp_idx <= reg_wdata[IDXW-1:0];
        end
        OFS_CTL1:    sh_ctl1[sel] <= reg_wdata;
        OFS_CTL2: begin
          sh_ctl2[sel] <= reg_wdata;
          act_q[sel]   <= '{base: sh_base[sel], limit: sh_lim[sel],
                            target: sh_tgt[sel], is_cfg: (sh_ctl1[sel] != 32'h0),
                            en: reg_wdata[31]};
        end
        OFS_BASE_LO: sh_base[sel][31:0]  <= reg_wdata;
        OFS_BASE_HI: sh_base[sel][63:32] <= reg_wdata;
        OFS_LIMIT:   sh_lim[sel]         <= reg_wdata;
        OFS_TGT_LO:  sh_tgt[sel][31:0]   <= reg_wdata;
        OFS_TGT_HI:  sh_tgt[sel][63:32]  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_PHY_DBG:  reg_rdata <= PHY_DBG_VAL;
        OFS_LINK_SPD: reg_rdata <= LINK_SPD_VAL;
        OFS_VPSEL:    reg_rdata <= {vp_dir, {(31-IDXW){1'b0}}, vp_idx};
        OFS_CTL1:     reg_rdata <= sh_ctl1[sel];
        OFS_CTL2:     reg_rdata <= sh_ctl2[sel];
        OFS_BASE_LO:  reg_rdata <= sh_base[sel][31:0];
        OFS_BASE_HI:  reg_rdata <= sh_base[sel][63:32];
        OFS_LIMIT:    reg_rdata <= sh_lim[sel];
        OFS_TGT_LO:   reg_rdata <= sh_tgt[sel][31:0];
        OFS_TGT_HI:   reg_rdata <= sh_tgt[sel][63:32];
        default:      reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/atu_match.sv
module atu_match
  import atu_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int CFG_OFS_W = 12,
  localparam int IDXW  = $clog2(NUM_WIN),
  localparam int NSLOT = 2 * NUM_WIN
) (
  input  win_t [NSLOT-1:0]       win_i,
  input  logic [63:0]            addr,
  input  logic                   inbound,
  output logic                   hit,
  output logic                   is_cfg,
  output logic [63:0]            out_addr,
  output logic [7:0]             bus,
  output logic [7:0]             devfn,
  output logic [CFG_OFS_W-1:0]   cfg_off
);
  win_t                w     [NUM_WIN];
  logic [63:0]         delta [NUM_WIN];
  logic [NUM_WIN-1:0]  hv;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign w[i]     = win_i[{inbound, IDXW'(i)}];
    assign delta[i] = addr - w[i].base;
    assign hv[i]    = w[i].en && (addr >= w[i].base) && (addr <= {32'h0, w[i].limit});
  end

  // Descending scan: the lowest hitting index is applied last and wins.
  always_comb begin
    hit      = 1'b0;
    is_cfg   = 1'b0;
    out_addr = '0;
    bus      = '0;
    devfn    = '0;
    cfg_off  = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hv[i]) begin
        hit    = 1'b1;
        is_cfg = w[i].is_cfg;
        if (w[i].is_cfg) begin
          out_addr = '0;
          bus      = w[i].target[31:24];
          devfn    = w[i].target[23:16];
          cfg_off  = delta[i][CFG_OFS_W-1:0];
        end else begin
          out_addr = w[i].target + delta[i];
          bus      = '0;
          devfn    = '0;
          cfg_off  = '0;
        end
      end
    end
  end
endmodule

// File: rtl/atu_window_unit.sv
module atu_window_unit
  import atu_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int CFG_OFS_W = 12,
  localparam int NSLOT = 2 * NUM_WIN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [11:0]           reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [63:0]           xl_addr,
  input  logic                  xl_inbound,
  output logic                  xl_hit,
  output logic                  xl_is_cfg,
  output logic [63:0]           xl_out_addr,
  output logic [7:0]            xl_bus,
  output logic [7:0]            xl_devfn,
  output logic [CFG_OFS_W-1:0]  xl_cfg_off
);
  win_t [NSLOT-1:0]       live;
  logic                   m_hit, m_cfg;
  logic [63:0]            m_addr;
  logic [7:0]             m_bus, m_devfn;
  logic [CFG_OFS_W-1:0]   m_off;

  atu_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .act_o(live)
  );

  atu_match #(.NUM_WIN(NUM_WIN), .CFG_OFS_W(CFG_OFS_W)) u_match (
    .win_i(live), .addr(xl_addr), .inbound(xl_inbound),
    .hit(m_hit), .is_cfg(m_cfg), .out_addr(m_addr),
    .bus(m_bus), .devfn(m_devfn), .cfg_off(m_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_hit      <= 1'b0;
      xl_is_cfg   <= 1'b0;
      xl_out_addr <= '0;
      xl_bus      <= '0;
      xl_devfn    <= '0;
      xl_cfg_off  <= '0;
    end else begin
      xl_hit      <= m_hit;
      xl_is_cfg   <= m_cfg;
      xl_out_addr <= m_addr;
      xl_bus      <= m_bus;
      xl_devfn    <= m_devfn;
      xl_cfg_off  <= m_off;
    end
  end
endmodule

// File: rtl/atu_window_unit_chk.sv
module atu_window_unit_chk #(
  parameter int NUM_WIN   = 4,
  parameter int CFG_OFS_W = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_rd,
  input logic [11:0]          reg_addr,
  input logic [31:0]          reg_rdata,
  input logic                 xl_hit,
  input logic                 xl_is_cfg,
  input logic [63:0]          xl_out_addr,
  input logic [7:0]           xl_bus,
  input logic [7:0]           xl_devfn,
  input logic [CFG_OFS_W-1:0] xl_cfg_off
);
  localparam logic [31:0] VP_KEEP = 32'h8000_0000 | 32'(NUM_WIN - 1);

  a_r10_link_speed_fixed: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 12'h80C) |=> (reg_rdata == 32'h0002_0000));

  a_r10_phy_dbg_fixed: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 12'h72C) |=> (reg_rdata == 32'h0000_0010));

  a_r1_vpsel_masked: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 12'h900) |=> ((reg_rdata & ~VP_KEEP) == 32'h0));

  a_r8_miss_quiet: assert property (@(posedge clk) disable iff (rst)
    !xl_hit |-> (xl_out_addr == 64'h0 && !xl_is_cfg && xl_bus == 8'h0 &&
                 xl_devfn == 8'h0 && xl_cfg_off == '0));

  a_r6_cfg_needs_hit: assert property (@(posedge clk) disable iff (rst)
    xl_is_cfg |-> (xl_hit && xl_out_addr == 64'h0));

  a_r5_mem_no_cfg_fields: assert property (@(posedge clk) disable iff (rst)
    (xl_hit && !xl_is_cfg) |-> (xl_bus == 8'h0 && xl_devfn == 8'h0 && xl_cfg_off == '0));
endmodule

bind atu_window_unit atu_window_unit_chk #(.NUM_WIN(NUM_WIN), .CFG_OFS_W(CFG_OFS_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .xl_hit(xl_hit), .xl_is_cfg(xl_is_cfg), .xl_out_addr(xl_out_addr),
  .xl_bus(xl_bus), .xl_devfn(xl_devfn), .xl_cfg_off(xl_cfg_off)
);

// File: tb/atu_window_unit_tb.sv
module atu_window_unit_tb;
  localparam int NW = 4;
  localparam int NS = 2 * NW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] xl_addr = '0;
  logic        xl_inbound = 1'b0;
  logic        xl_hit, xl_is_cfg;
  logic [63:0] xl_out_addr;
  logic [7:0]  xl_bus, xl_devfn;
  logic [11:0] xl_cfg_off;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  atu_window_unit #(.NUM_WIN(NW), .CFG_OFS_W(12)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_addr(xl_addr),
    .xl_inbound(xl_inbound), .xl_hit(xl_hit), .xl_is_cfg(xl_is_cfg),
    .xl_out_addr(xl_out_addr), .xl_bus(xl_bus), .xl_devfn(xl_devfn),
    .xl_cfg_off(xl_cfg_off)
  );

  // Bench model built from the requirements.
  logic [63:0] m_sb [NS], m_st [NS], a_b [NS], a_t [NS];
  logic [31:0] m_sl [NS], m_c1 [NS], m_c2 [NS], a_l [NS];
  bit          a_cfg [NS], a_en [NS];
  bit          m_dir;
  int          m_idx;

  function automatic void model_reset();
    for (int s = 0; s < NS; s++) begin
      m_sb[s] = 0; m_st[s] = 0; m_sl[s] = 32'hFFFF_FFFF; m_c1[s] = 0;
      m_c2[s] = (s == NW) ? 32'h8000_0000 : 32'h0;
      a_b[s] = 0; a_t[s] = 0; a_l[s] = 32'hFFFF_FFFF; a_cfg[s] = 0; a_en[s] = (s == NW);
    end
    m_dir = 0; m_idx = 0;
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    int s = (m_dir ? NW : 0) + m_idx;
    case (a)
      12'h900: begin m_dir = d[31]; m_idx = int'(d[1:0]); end
      12'h904: m_c1[s] = d;
      12'h908: begin
        m_c2[s] = d; a_b[s] = m_sb[s]; a_t[s] = m_st[s]; a_l[s] = m_sl[s];
        a_cfg[s] = (m_c1[s] != 0); a_en[s] = d[31];
      end
      12'h90C: m_sb[s][31:0] = d;
      12'h910: m_sb[s][63:32] = d;
      12'h914: m_sl[s] = d;
      12'h918: m_st[s][31:0] = d;
      12'h91C: m_st[s][63:32] = d;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int s = (m_dir ? NW : 0) + m_idx;
    case (a)
      12'h72C: return 32'h0000_0010;
      12'h80C: return 32'h0002_0000;
      12'h900: return {m_dir, 29'h0, 2'(m_idx)};
      12'h904: return m_c1[s];
      12'h908: return m_c2[s];
      12'h90C: return m_sb[s][31:0];
      12'h910: return m_sb[s][63:32];
      12'h914: return m_sl[s];
      12'h918: return m_st[s][31:0];
      12'h91C: return m_st[s][63:32];
      default: return 32'h0;
    endcase
  endfunction

  // Packed expected result: {hit, cfg, out_addr, bus, devfn, off} = 94 bits
  function automatic logic [93:0] model_xl(input logic [63:0] a, input bit inb);
    logic [93:0] r = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      int s = (inb ? NW : 0) + i;
      if (a_en[s] && a >= a_b[s] && a <= {32'h0, a_l[s]}) begin
        logic [63:0] dl = a - a_b[s];
        if (a_cfg[s]) r = {1'b1, 1'b1, 64'h0, a_t[s][31:24], a_t[s][23:16], dl[11:0]};
        else          r = {1'b1, 1'b0, a_t[s] + dl, 8'h0, 8'h0, 12'h0};
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [93:0] act, input logic [93:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    model_write(a, d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    logic [31:0] e = model_read(a);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, {62'h0, reg_rdata}, {62'h0, e});
  endtask

  task automatic xl(input string tag, input logic [63:0] a, input bit inb);
    logic [93:0] e = model_xl(a, inb);
    @(negedge clk);
    xl_addr = a; xl_inbound = inb;
    @(negedge clk);
    check(tag, {xl_hit, xl_is_cfg, xl_out_addr, xl_bus, xl_devfn, xl_cfg_off}, e);
  endtask

  // Program the selected window fully and commit it.
  task automatic prog(input logic [31:0] vp, input logic [31:0] typ, input logic [63:0] b,
                      input logic [31:0] l, input logic [63:0] t, input logic [31:0] c2);
    wr(12'h900, vp);
    wr(12'h904, typ); wr(12'h90C, b[31:0]); wr(12'h910, b[63:32]);
    wr(12'h914, l); wr(12'h918, t[31:0]); wr(12'h91C, t[63:32]);
    wr(12'h908, c2);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [11:0] ofs [10];
    ofs = '{12'h900, 12'h904, 12'h908, 12'h90C, 12'h910, 12'h914, 12'h918, 12'h91C, 12'h80C, 12'h72C};
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    check("R9 reset outputs", {xl_hit, xl_is_cfg, xl_out_addr, xl_bus, xl_devfn, xl_cfg_off}, '0);
    rd("R9 vpsel reset", 12'h900);
    rd("R9 limit reset", 12'h914);
    check("R9 limit value", {62'h0, reg_rdata}, {62'h0, 32'hFFFF_FFFF});
    xl("R9 R11 inbound identity", 64'h1234_5678, 1'b1);
    check("R9 identity value", {30'h0, xl_out_addr}, {30'h0, 64'h1234_5678});
    xl("R9 inbound above 4G misses", 64'h1_0000_0000, 1'b1);
    xl("R9 R8 outbound miss", 64'h100, 1'b0);

    // R10 fixed status registers
    rd("R10 link speed", 12'h80C);
    rd("R10 phy debug", 12'h72C);
    wr(12'h80C, 32'h0); wr(12'h72C, 32'h0);
    rd("R10 link speed after write", 12'h80C);
    check("R10 link speed const", {62'h0, reg_rdata}, {62'h0, 32'h0002_0000});
    rd("R10 phy debug after write", 12'h72C);
    check("R10 phy debug const", {62'h0, reg_rdata}, {62'h0, 32'h0000_0010});
    rd("R10 unmapped", 12'h000);

    // R1 viewport masking
    wr(12'h900, 32'hFFFF_FFFF);
    rd("R1 vpsel masked", 12'h900);
    check("R1 vpsel value", {62'h0, reg_rdata}, {62'h0, 32'h8000_0003});

    // R3 staging: outbound window 1
    wr(12'h900, 32'h1);
    wr(12'h904, 32'h0); wr(12'h90C, 32'h1000); wr(12'h910, 32'h0);
    wr(12'h914, 32'h1FFF); wr(12'h918, 32'h5000_0000); wr(12'h91C, 32'h1);
    xl("R3 staged not live", 64'h1800, 1'b0);
    rd("R2 staged base readback", 12'h90C);
    wr(12'h908, 32'h8000_0000);
    xl("R5 memory remap", 64'h1800, 1'b0);
    check("R5 remap value", {30'h0, xl_out_addr}, {30'h0, 64'h1_5000_0800});
    xl("R4 limit inclusive", 64'h1FFF, 1'b0);
    xl("R4 above limit", 64'h2000, 1'b0);
    xl("R4 below base", 64'hFFF, 1'b0);
    xl("R4 base inclusive", 64'h1000, 1'b0);

    // R7 priority: window 0 overlaps window 1
    prog(32'h0, 32'h0, 64'h1800, 32'h2FFF, 64'h9000_0000, 32'h8000_0000);
    xl("R7 lowest wins", 64'h1900, 1'b0);
    check("R7 value", {30'h0, xl_out_addr}, {30'h0, 64'h9000_0100});
    xl("R7 only window1", 64'h1200, 1'b0);

    // R6 configuration window on outbound 2
    prog(32'h2, 32'h4, 64'h4000_0000, 32'h4FFF_FFFF, 64'h0312_0000, 32'h8000_0000);
    xl("R6 cfg decode", 64'h4000_1A34, 1'b0);
    check("R6 fields", {62'h0, xl_bus, xl_devfn, 4'h0, xl_cfg_off, 4'h0},
          {62'h0, 8'h03, 8'h12, 4'h0, 12'hA34, 4'h0});
    wr(12'h904, 32'h0);
    xl("R3 type change staged", 64'h4000_0010, 1'b0);
    wr(12'h908, 32'h8000_0000);
    xl("R3 type change committed", 64'h4000_0010, 1'b0);
    wr(12'h908, 32'h0);
    xl("R8 disabled window misses", 64'h4000_0010, 1'b0);

    // R2/R4 inbound window 3, direction separation
    prog(32'h8000_0003, 32'h0, 64'h0, 32'h0, 64'hAB00, 32'h8000_0000);
    xl("R4 inbound direction", 64'h1900, 1'b1);
    rd("R2 inbound target readback", 12'h918);

    // Constrained random mix
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom_range(0, 5));
      if (op <= 2) begin
        logic [11:0] a = ofs[$urandom_range(0, 9)];
        logic [31:0] d = $urandom;
        case (a)
          12'h90C: d = d & 32'h000F_F000;
          12'h910: d = ($urandom_range(0, 7) == 0) ? 32'h1 : 32'h0;
          12'h914: d = d & 32'h001F_FFFF;
          12'h904: d = ($urandom_range(0, 1) == 0) ? 32'h0 : 32'(d[2:0]);
          default: ;
        endcase
        wr(a, d);
      end else if (op <= 4) begin
        logic [63:0] a = {(($urandom_range(0, 15) == 0) ? 32'h1 : 32'h0), $urandom & 32'h001F_FFFF};
        xl("R4 R5 R6 R7 random translate", a, 1'($urandom_range(0, 1)));
      end else begin
        rd("R2 random readback", ofs[$urandom_range(0, 9)]);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule